// File: doc/BRIEF.md
# Scan Test Application Sequencer

This block applies a set of stored test patterns to a small sequential circuit through a single mux-D scan chain. The circuit is part of the block. On `start` the sequencer shifts the first pattern into the chain, one bit per clock, with scan enable high. It then drops scan enable and drives the pattern's primary-input word. It compares the primary outputs against an expected word, then gives the chain one capture cycle so that every flop takes its functional next state. After that, scan enable rises again. The captured response is shifted out while the next pattern is shifted in over the same cycles.

After the last pattern's capture, the chain is unloaded once more with zeros on scan-in so that the last response can also be compared. Expected primary outputs and expected responses come from an internal table that is computed from the fault-free circuit equations. Any mismatch sets a sticky fail flag and records the index of the first failing pattern. When the run ends, `done` stays high until the next `start`, and `pass` is high only if no mismatch was seen.

The states of the controller, in order, are:

- `ST_IDLE`: after reset.
- `ST_LOAD`: first load.
- `ST_FORCE`: drive the primary inputs.
- `ST_MEASURE`: compare the primary outputs.
- `ST_CAPTURE`: one functional clock.
- `ST_SHIFT`: unload the response while loading the next pattern.
- `ST_UNLOAD`: final unload with zero fill.
- `ST_RESP`: compare the response.
- `ST_FIN`: finished.

The transitions are:

- IDLE→LOAD and FIN→LOAD on `start`.
- LOAD→FORCE after the last shift.
- FORCE→MEASURE→CAPTURE unconditionally.
- CAPTURE→SHIFT if more patterns remain, otherwise CAPTURE→UNLOAD.
- SHIFT→RESP and UNLOAD→RESP after the last shift.
- RESP→FORCE if more patterns remain, otherwise RESP→FIN.

Top module: `scanapp_top`

## Requirements
- R1: While reset is held and until the first `start`, `done`, `pass`, `fail`, `scan_en` and `cap_en` are 0, and `pat_cnt` and `fail_idx` are 0.
- R2: When `scan_en` is 1, each clock moves the chain one place: flop 0 takes `scan_in`, flop i takes flop i-1, and `scan_out` is flop CHAIN_LEN-1. Every shift phase keeps `scan_en` high for exactly CHAIN_LEN consecutive cycles.
- R3: A `start` seen in `ST_IDLE` or `ST_FIN` begins the first load on the next clock. A `start` during a run has no effect, so a run lasts CHAIN_LEN + NUM_PAT·(CHAIN_LEN+4) cycles before `done`. Bits shifted out during the first load are never compared.
- R4: Bit CHAIN_LEN-1 of a pattern word is shifted in first. After the load, flop i holds bit i, so the first bit sits in the flop farthest from scan-in. Response bits leave tail first and are assembled most-significant first.
- R5: After each load there is one force cycle and one measure cycle, then the capture cycle, all with `scan_en` low. `cut_pi` carries the pattern's input word through all three cycles and is 0 in every other state.
- R6: Each pattern gets exactly one capture cycle. In that cycle `cap_en` is 1 and `scan_en` is 0, and it is preceded by a cycle with `scan_en` low. Every flop loads its functional next state at once.
- R7: After the capture of pattern k (k < last), the following shift phase drives pattern k+1 on `scan_in` while `scan_out` delivers the captured response of pattern k.
- R8: After the capture of the last pattern, one unload phase drives 0 on `scan_in`. `done` then rises and stays high, with `scan_en` and `cap_en` low, until a new `start`.
- R9: Pattern 0 is 100101011 and pattern 1 is 111100111, written most-significant first. For k ≥ 2, pattern k is pattern k-1 rotated left by one, XOR (37·k mod 2^CHAIN_LEN). The input word for pattern k is (5·k+3) mod 2^IO_W.
- R10: For the example circuit, next-state bit i is s[(i+1) mod N] XOR (s[(i+2) mod N] AND pi[i mod IO_W]), and output bit j is (s[j] AND pi[j]) XOR s[N-1-j]. The parameter FAULT_EN forces next-state bit FAULT_BIT to 0, while the expected table stays fault-free.
- R11: A primary-output mismatch in the measure cycle, or a response mismatch in `ST_RESP`, sets `fail`, which stays set. `fail_idx` keeps the index of the first failing pattern. `pass` equals `done` AND NOT `fail`. A `start` from `ST_FIN` clears `fail` and `fail_idx`.
- R12: `pat_cnt` is the index of the pattern being forced and captured. It advances by one in `ST_RESP` when more patterns remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run from idle or finished |
| done | output | 1 | Run finished, held until next start |
| pass | output | 1 | Finished with no mismatch |
| fail | output | 1 | Sticky mismatch flag |
| fail_idx | output | IDX_W | Index of the first failing pattern |
| pat_cnt | output | IDX_W | Current pattern index |
| scan_en | output | 1 | Chain shift mode |
| scan_in | output | 1 | Bit entering the chain |
| scan_out | output | 1 | Bit leaving the chain |
| cap_en | output | 1 | Capture (functional clock) enable |
| cut_pi | output | IO_W | Primary inputs driven into the circuit |
| cut_po | output | IO_W | Primary outputs of the circuit |

## Verification
The bench builds three copies of the block.

- The default copy uses NUM_PAT=2, so it runs the two example patterns. Every shift word, response, forced input and measured output of this copy is checked cycle by cycle.
- A copy with NUM_PAT=6 reaches the computed patterns beyond the example pair and a three-bit pattern index.
- A copy with NUM_PAT=4, FAULT_EN=1 and FAULT_BIT=3 carries a stuck-at-0 next-state bit. This makes a response mismatch reachable, so the sticky flag, the first-failure index and the clearing on restart are all exercised.

// File: rtl/scanapp_pkg.sv
`timescale 1ns/1ps
package scanapp_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LOAD,
        ST_FORCE,
        ST_MEASURE,
        ST_CAPTURE,
        ST_SHIFT,
        ST_UNLOAD,
        ST_RESP,
        ST_FIN
    } seq_state_t;

endpackage

// File: rtl/scanapp_cut.sv
`timescale 1ns/1ps
// Example circuit under test: CHAIN_LEN mux-D scan flops with a small
// next-state and output logic cloud. No reset: contents are unknown until loaded.
module scanapp_cut #(
    parameter int CHAIN_LEN = 9,
    parameter int IO_W      = 4,
    parameter bit FAULT_EN  = 1'b0,
    parameter int FAULT_BIT = 0
) (
    input  logic            clk,
    input  logic            se,
    input  logic            si,
    input  logic            cap_en,
    input  logic [IO_W-1:0] pi,
    output logic            so,
    output logic [IO_W-1:0] po
);
    localparam logic [CHAIN_LEN-1:0] FMASK =
        FAULT_EN ? (CHAIN_LEN'(1) << FAULT_BIT) : '0;

    logic [CHAIN_LEN-1:0] ff_q;
    logic [CHAIN_LEN-1:0] nxt_raw;
    logic [CHAIN_LEN-1:0] nxt;

    for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_next
        assign nxt_raw[i] = ff_q[(i + 1) % CHAIN_LEN]
                          ^ (ff_q[(i + 2) % CHAIN_LEN] & pi[i % IO_W]);
    end

    // optional stuck-at-0 on one functional input
    assign nxt = nxt_raw & ~FMASK;

    for (genvar j = 0; j < IO_W; j++) begin : g_out
        assign po[j] = (ff_q[j] & pi[j]) ^ ff_q[CHAIN_LEN-1-j];
    end

    always_ff @(posedge clk) begin
        if (se) begin
            ff_q <= {ff_q[CHAIN_LEN-2:0], si};
        end else if (cap_en) begin
            ff_q <= nxt;
        end
    end

    assign so = ff_q[CHAIN_LEN-1];

endmodule

// File: rtl/scanapp_patrom.sv
`timescale 1ns/1ps
// Computed pattern store with fault-free expected values.
module scanapp_patrom #(
    parameter int CHAIN_LEN = 9,
    parameter int IO_W      = 4,
    parameter int NUM_PAT   = 2,
    parameter logic [CHAIN_LEN-1:0] PAT_A = 9'b100101011,
    parameter logic [CHAIN_LEN-1:0] PAT_B = 9'b111100111,
    localparam int IDX_W = (NUM_PAT > 1) ? $clog2(NUM_PAT) : 1
) (
    input  logic [IDX_W-1:0]     idx,
    output logic [CHAIN_LEN-1:0] pat_now,
    output logic [CHAIN_LEN-1:0] pat_next,
    output logic [IO_W-1:0]      pi_now,
    output logic [IO_W-1:0]      po_exp,
    output logic [CHAIN_LEN-1:0] rsp_exp
);
    function automatic logic [CHAIN_LEN-1:0] f_pat(input int k);
        logic [CHAIN_LEN-1:0] p;
        p = PAT_B;
        for (int j = 2; j < NUM_PAT; j++) begin
            if (j <= k) begin
                p = {p[CHAIN_LEN-2:0], p[CHAIN_LEN-1]} ^ CHAIN_LEN'(37 * j);
            end
        end
        return (k == 0) ? PAT_A : p;
    endfunction

    function automatic logic [IO_W-1:0] f_pi(input int k);
        return IO_W'(5 * k + 3);
    endfunction

    function automatic logic [CHAIN_LEN-1:0] f_nxt(input logic [CHAIN_LEN-1:0] s,
                                                   input logic [IO_W-1:0] p);
        logic [CHAIN_LEN-1:0] r;
        for (int i = 0; i < CHAIN_LEN; i++) begin
            r[i] = s[(i + 1) % CHAIN_LEN] ^ (s[(i + 2) % CHAIN_LEN] & p[i % IO_W]);
        end
        return r;
    endfunction

    function automatic logic [IO_W-1:0] f_po(input logic [CHAIN_LEN-1:0] s,
                                             input logic [IO_W-1:0] p);
        logic [IO_W-1:0] r;
        for (int j = 0; j < IO_W; j++) begin
            r[j] = (s[j] & p[j]) ^ s[CHAIN_LEN-1-j];
        end
        return r;
    endfunction

    logic [CHAIN_LEN-1:0] pat_tab [NUM_PAT];
    logic [IO_W-1:0]      pi_tab  [NUM_PAT];
    logic [IO_W-1:0]      po_tab  [NUM_PAT];
    logic [CHAIN_LEN-1:0] rsp_tab [NUM_PAT];

    for (genvar k = 0; k < NUM_PAT; k++) begin : g_tab
        assign pat_tab[k] = f_pat(k);
        assign pi_tab[k]  = f_pi(k);
        assign po_tab[k]  = f_po(f_pat(k), f_pi(k));
        assign rsp_tab[k] = f_nxt(f_pat(k), f_pi(k));
    end

    logic [IDX_W-1:0] nidx;
    assign nidx = (idx == IDX_W'(NUM_PAT - 1)) ? idx : idx + IDX_W'(1);

    assign pat_now  = pat_tab[idx];
    assign pat_next = pat_tab[nidx];
    assign pi_now   = pi_tab[idx];
    assign po_exp   = po_tab[idx];
    assign rsp_exp  = rsp_tab[idx];

endmodule

// File: rtl/scanapp_fsm.sv
`timescale 1ns/1ps
// Sequencer: load, force, measure, capture, overlapped unload/load, compare.
module scanapp_fsm
    import scanapp_pkg::*;
#(
    parameter int CHAIN_LEN = 9,
    parameter int IO_W      = 4,
    parameter int NUM_PAT   = 2,
    localparam int IDX_W = (NUM_PAT > 1) ? $clog2(NUM_PAT) : 1,
    localparam int CNT_W = $clog2(CHAIN_LEN)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 cut_so,
    input  logic [IO_W-1:0]      cut_po,
    input  logic [CHAIN_LEN-1:0] pat_now,
    input  logic [CHAIN_LEN-1:0] pat_next,
    input  logic [IO_W-1:0]      pi_now,
    input  logic [IO_W-1:0]      po_exp,
    input  logic [CHAIN_LEN-1:0] rsp_exp,
    output logic                 scan_en,
    output logic                 scan_in,
    output logic                 cap_en,
    output logic [IO_W-1:0]      pi_drv,
    output logic [IDX_W-1:0]     idx,
    output logic                 done,
    output logic                 fail,
    output logic [IDX_W-1:0]     fail_idx
);
    seq_state_t st, st_n;

    logic [CNT_W-1:0]     cnt;
    logic [CNT_W-1:0]     bit_sel;
    logic [CHAIN_LEN-1:0] rsp;
    logic                 last_bit;
    logic                 last_pat;
    logic                 launch;
    logic                 mis;

    assign last_bit = (cnt == CNT_W'(CHAIN_LEN - 1));
    assign last_pat = (idx == IDX_W'(NUM_PAT - 1));
    assign launch   = ((st == ST_IDLE) || (st == ST_FIN)) && start;
    assign bit_sel  = CNT_W'(CHAIN_LEN - 1) - cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_n;
        end
    end

    // transitions
    always_comb begin
        st_n = st;
        unique case (st)
            ST_IDLE, ST_FIN:     if (start) st_n = ST_LOAD;
            ST_LOAD:             if (last_bit) st_n = ST_FORCE;
            ST_FORCE:            st_n = ST_MEASURE;
            ST_MEASURE:          st_n = ST_CAPTURE;
            ST_CAPTURE:          st_n = last_pat ? ST_UNLOAD : ST_SHIFT;
            ST_SHIFT, ST_UNLOAD: if (last_bit) st_n = ST_RESP;
            ST_RESP:             st_n = last_pat ? ST_FIN : ST_FORCE;
            default:             st_n = ST_IDLE;
        endcase
    end

    // Moore outputs
    always_comb begin
        scan_en = 1'b0;
        scan_in = 1'b0;
        cap_en  = 1'b0;
        pi_drv  = '0;
        done    = 1'b0;
        unique case (st)
            ST_LOAD: begin
                scan_en = 1'b1;
                scan_in = pat_now[bit_sel];
            end
            ST_SHIFT: begin
                scan_en = 1'b1;
                scan_in = pat_next[bit_sel];
            end
            ST_UNLOAD: begin
                scan_en = 1'b1;
            end
            ST_FORCE, ST_MEASURE: begin
                pi_drv = pi_now;
            end
            ST_CAPTURE: begin
                pi_drv = pi_now;
                cap_en = 1'b1;
            end
            ST_FIN: begin
                done = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign mis = ((st == ST_MEASURE) && (cut_po != po_exp))
              || ((st == ST_RESP) && (rsp != rsp_exp));

    // datapath: shift counter, response collector, index, verdict
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            rsp      <= '0;
            idx      <= '0;
            fail     <= 1'b0;
            fail_idx <= '0;
        end else begin
            if (scan_en) begin
                cnt <= last_bit ? '0 : cnt + CNT_W'(1);
                rsp <= {rsp[CHAIN_LEN-2:0], cut_so};
            end else begin
                cnt <= '0;
            end
            if (launch) begin
                idx      <= '0;
                fail     <= 1'b0;
                fail_idx <= '0;
            end else begin
                if ((st == ST_RESP) && !last_pat) begin
                    idx <= idx + IDX_W'(1);
                end
                if (mis && !fail) begin
                    fail     <= 1'b1;
                    fail_idx <= idx;
                end
            end
        end
    end

endmodule

// File: rtl/scanapp_top.sv
`timescale 1ns/1ps
module scanapp_top #(
    parameter int CHAIN_LEN = 9,
    parameter int IO_W      = 4,
    parameter int NUM_PAT   = 2,
    parameter logic [CHAIN_LEN-1:0] PAT_A = 9'b100101011,
    parameter logic [CHAIN_LEN-1:0] PAT_B = 9'b111100111,
    parameter bit FAULT_EN  = 1'b0,
    parameter int FAULT_BIT = 0,
    localparam int IDX_W = (NUM_PAT > 1) ? $clog2(NUM_PAT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             done,
    output logic             pass,
    output logic             fail,
    output logic [IDX_W-1:0] fail_idx,
    output logic [IDX_W-1:0] pat_cnt,
    output logic             scan_en,
    output logic             scan_in,
    output logic             scan_out,
    output logic             cap_en,
    output logic [IO_W-1:0]  cut_pi,
    output logic [IO_W-1:0]  cut_po
);
    logic [CHAIN_LEN-1:0] pat_now, pat_next, rsp_exp;
    logic [IO_W-1:0]      pi_now, po_exp;

    scanapp_patrom #(
        .CHAIN_LEN(CHAIN_LEN), .IO_W(IO_W), .NUM_PAT(NUM_PAT),
        .PAT_A(PAT_A), .PAT_B(PAT_B)
    ) u_rom (
        .idx      (pat_cnt),
        .pat_now  (pat_now),
        .pat_next (pat_next),
        .pi_now   (pi_now),
        .po_exp   (po_exp),
        .rsp_exp  (rsp_exp)
    );

    scanapp_fsm #(
        .CHAIN_LEN(CHAIN_LEN), .IO_W(IO_W), .NUM_PAT(NUM_PAT)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cut_so   (scan_out),
        .cut_po   (cut_po),
        .pat_now  (pat_now),
        .pat_next (pat_next),
        .pi_now   (pi_now),
        .po_exp   (po_exp),
        .rsp_exp  (rsp_exp),
        .scan_en  (scan_en),
        .scan_in  (scan_in),
        .cap_en   (cap_en),
        .pi_drv   (cut_pi),
        .idx      (pat_cnt),
        .done     (done),
        .fail     (fail),
        .fail_idx (fail_idx)
    );

    scanapp_cut #(
        .CHAIN_LEN(CHAIN_LEN), .IO_W(IO_W),
        .FAULT_EN(FAULT_EN), .FAULT_BIT(FAULT_BIT)
    ) u_cut (
        .clk    (clk),
        .se     (scan_en),
        .si     (scan_in),
        .cap_en (cap_en),
        .pi     (cut_pi),
        .so     (scan_out),
        .po     (cut_po)
    );

    assign pass = done & ~fail;

endmodule

// File: rtl/scanapp_chk.sv
`timescale 1ns/1ps
module scanapp_chk #(
    parameter int CHAIN_LEN = 9,
    parameter int IO_W      = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            done,
    input logic            fail,
    input logic            scan_en,
    input logic            cap_en,
    input logic [IO_W-1:0] cut_pi
);
    localparam int RW = $clog2(CHAIN_LEN + 1) + 1;

    logic [RW-1:0] se_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            se_run <= '0;
        end else if (scan_en) begin
            se_run <= se_run + RW'(1);
        end else begin
            se_run <= '0;
        end
    end

    // R2: a shift phase ends after exactly CHAIN_LEN cycles
    p_shift_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scan_en) |-> (se_run == RW'(CHAIN_LEN)));

    // R2: a shift phase never runs longer
    p_shift_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |-> (se_run < RW'(CHAIN_LEN)));

    // R6: capture only in functional mode, after a non-shift cycle
    p_cap_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |-> (!scan_en && !$past(scan_en)));

    // R6: one capture cycle at a time
    p_cap_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> !cap_en);

    // R5: inputs held from measure into capture
    p_pi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |-> $stable(cut_pi));

    // R8: finished state is held and quiet
    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!scan_en && !cap_en));

    // R11: fail flag is sticky within a run
    p_fail_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> fail);

endmodule

bind scanapp_top scanapp_chk #(
    .CHAIN_LEN(CHAIN_LEN), .IO_W(IO_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .done    (done),
    .fail    (fail),
    .scan_en (scan_en),
    .cap_en  (cap_en),
    .cut_pi  (cut_pi)
);

// File: tb/scanapp_top_test.sv
`timescale 1ns/1ps
module scanapp_top_test;
    localparam int N       = 9;
    localparam int W       = 4;
    localparam int P_MAIN  = 2;
    localparam int P_LONG  = 6;
    localparam int P_BAD   = 4;
    localparam int BAD_BIT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // main copy
    logic done_m, pass_m, fail_m, se_m, si_m, so_m, cap_m;
    logic [0:0] fidx_m, cnt_m;
    logic [W-1:0] pi_m, po_m;
    // long copy
    logic done_l, pass_l, fail_l, se_l, si_l, so_l, cap_l;
    logic [2:0] fidx_l, cnt_l;
    logic [W-1:0] pi_l, po_l;
    // faulty copy
    logic done_b, pass_b, fail_b, se_b, si_b, so_b, cap_b;
    logic [1:0] fidx_b, cnt_b;
    logic [W-1:0] pi_b, po_b;

    scanapp_top #(.NUM_PAT(P_MAIN)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done_m), .pass(pass_m),
        .fail(fail_m), .fail_idx(fidx_m), .pat_cnt(cnt_m), .scan_en(se_m),
        .scan_in(si_m), .scan_out(so_m), .cap_en(cap_m), .cut_pi(pi_m), .cut_po(po_m));

    scanapp_top #(.NUM_PAT(P_LONG)) uut_long (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done_l), .pass(pass_l),
        .fail(fail_l), .fail_idx(fidx_l), .pat_cnt(cnt_l), .scan_en(se_l),
        .scan_in(si_l), .scan_out(so_l), .cap_en(cap_l), .cut_pi(pi_l), .cut_po(po_l));

    scanapp_top #(.NUM_PAT(P_BAD), .FAULT_EN(1'b1), .FAULT_BIT(BAD_BIT)) uut_bad (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done_b), .pass(pass_b),
        .fail(fail_b), .fail_idx(fidx_b), .pat_cnt(cnt_b), .scan_en(se_b),
        .scan_in(si_b), .scan_out(so_b), .cap_en(cap_b), .cut_pi(pi_b), .cut_po(po_b));

    // ---- reference functions from the requirements (R9, R10)
    function automatic logic [N-1:0] b_pat(input int k);
        logic [N-1:0] p;
        p = 9'b111100111;
        if (k == 0) return 9'b100101011;
        for (int j = 2; j <= k; j++) p = {p[N-2:0], p[N-1]} ^ N'(37 * j);
        return p;
    endfunction

    function automatic logic [W-1:0] b_pi(input int k);
        return W'(5 * k + 3);
    endfunction

    function automatic logic [N-1:0] b_nxt(input logic [N-1:0] s, input logic [W-1:0] p);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = s[(i + 1) % N] ^ (s[(i + 2) % N] & p[i % W]);
        return r;
    endfunction

    function automatic logic [W-1:0] b_po(input logic [N-1:0] s, input logic [W-1:0] p);
        logic [W-1:0] r;
        for (int j = 0; j < W; j++) r[j] = (s[j] & p[j]) ^ s[N-1-j];
        return r;
    endfunction

    function automatic int b_first_fail(input int npat, input int fbit);
        for (int k = 0; k < npat; k++) begin
            logic [N-1:0] g;
            g = b_nxt(b_pat(k), b_pi(k));
            if (g[fbit]) return k;
        end
        return -1;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---- watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---- cycle monitor on the main copy
    int ph = 0;
    int run_len = 0;
    int capn = 0;
    logic se_q = 1'b0;
    logic done_q = 1'b0;
    logic [N-1:0] si_w = '0;
    logic [N-1:0] so_w = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            ph = 0; run_len = 0; capn = 0; se_q = 1'b0; done_q = 1'b0;
        end else begin
            if (se_m) begin
                run_len++;
                si_w = {si_w[N-2:0], si_m};
                so_w = {so_w[N-2:0], so_m};
                if (run_len == 1) chk("R5", "PI idle during shift", int'(pi_m), 0);
            end else if (se_q) begin
                chk("R2", "shift phase length", run_len, N);
                if (ph < P_MAIN) chk("R4", "scan-in word (R9 pattern)", int'(si_w), int'(b_pat(ph)));
                else             chk("R8", "zero fill on final unload", int'(si_w), 0);
                if (ph >= 1) chk("R7", "unloaded response", int'(so_w),
                                 int'(b_nxt(b_pat(ph - 1), b_pi(ph - 1))));
                ph++;
                run_len = 0;
            end
            if (cap_m) begin
                chk("R5", "forced PI at capture", int'(pi_m), int'(b_pi(ph - 1)));
                chk("R10", "measured PO", int'(po_m), int'(b_po(b_pat(ph - 1), b_pi(ph - 1))));
                chk("R6", "scan enable at capture", int'(se_m), 0);
                chk("R12", "pattern counter", int'(cnt_m), ph - 1);
                capn++;
            end
            if (done_m && !done_q) begin
                chk("R6", "capture pulses per run", capn, P_MAIN);
                ph = 0;
                capn = 0;
            end
            se_q = se_m;
            done_q = done_m;
        end
    end

    // ---- main sequence
    int gap;
    int mid;
    int len;
    int exp_bad;

    initial begin
        void'($urandom(32'd7715));
        exp_bad = b_first_fail(P_BAD, BAD_BIT);
        repeat (4) @(negedge clk);
        chk("R1", "done in reset", int'(done_m), 0);
        chk("R1", "pass in reset", int'(pass_m), 0);
        chk("R1", "fail in reset", int'(fail_b), 0);
        chk("R1", "scan_en in reset", int'(se_m), 0);
        chk("R1", "cap_en in reset", int'(cap_m), 0);
        chk("R1", "pat_cnt in reset", int'(cnt_l), 0);
        chk("R1", "fail_idx in reset", int'(fidx_b), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "idle without start", int'(done_m | se_m), 0);

        for (int r = 0; r < 4; r++) begin
            gap = 1 + int'($urandom % 8);
            mid = 3 + int'($urandom % 15);
            len = 0;
            repeat (gap) @(negedge clk);
            if (r > 0) chk("R8", "done held before restart", int'(done_m), 1);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            if (r > 0) begin
                chk("R11", "fail cleared by restart", int'(fail_b), 0);
                chk("R11", "fail_idx cleared by restart", int'(fidx_b), 0);
            end
            while (!done_m) begin
                len++;
                start = (len == mid);
                @(negedge clk);
            end
            start = 1'b0;
            chk("R3", "run length with mid-run start", len, N + P_MAIN * (N + 4));
            chk("R11", "pass main", int'(pass_m), 1);
            chk("R3", "first-load bits not compared", int'(fail_m), 0);
            while (!(done_l && done_b)) @(negedge clk);
            chk("R9", "pass long pattern set", int'(pass_l), 1);
            chk("R11", "faulty copy fail", int'(fail_b), exp_bad >= 0 ? 1 : 0);
            chk("R11", "faulty copy pass", int'(pass_b), exp_bad >= 0 ? 0 : 1);
            if (exp_bad >= 0) chk("R11", "first failing index", int'(fidx_b), exp_bad);
            chk("R12", "pat_cnt at end of long run", int'(cnt_l), P_LONG - 1);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule